// File: doc/BRIEF.md
# Flash Rescue Sequence Generator

This block sits on the host side of a serial flash link. It drives the flash's chip select, serial clock and two data pins through a fixed recovery pattern. The pattern brings a device that woke up in an unknown protocol or execute-in-place state back to extended SPI with execute-in-place off. A single `start_i` pulse launches the whole pattern. `busy_o` stays high until it is finished, and `done_o` pulses once near the end.

The pattern has two parts in strict order. The first part exits execute-in-place: three chip-select-low bursts of 7, 13 and 25 clock pulses, with DQ0 held high. The second part forces normal SPI: one burst of 8 clock pulses with both DQ0 and DQ3 held high. In every burst, chip select rises after the last counted pulse and before the next pulse would begin. Between bursts chip select stays high for a minimum time. That time is given in nanoseconds and rounded up to whole system clock cycles.

The SCK half-period is a parameter counted in system clock cycles. Chip select falls one half-period before the first rising edge of SCK. It rises one half-period after the last falling edge. The normal command path and any later rewrite of the non-volatile configuration belong to other logic.

Top module: `frs_rescue_gen`

## Requirements
- R1: Out of reset, and whenever `busy_o` is low, `cs_n_o` is 1, `sck_o` is 0, `done_o` is 0, and `dq0_oe_o` and `dq3_oe_o` are 0.
- R2: A start pulse seen while idle produces exactly four chip-select-low windows. They carry 7, 13, 25 and then 8 SCK rising edges, in that order.
- R3: `sck_o` is 0 in every cycle in which `cs_n_o` is 1. Each SCK high phase and each low phase lasts `SCK_HALF_CYC` system cycles.
- R4: Chip select stays high for at least ceil(`CS_HIGH_NS` * 1000 / `CLK_PERIOD_PS`) cycles before each fall. This holds between bursts and also before the first burst of a new sequence.
- R5: While `busy_o` is high, `dq0_oe_o` is 1 and `dq0_o` is 1.
- R6: During the first three windows `dq3_oe_o` is 0. During the fourth window `dq3_oe_o` is 1 and `dq3_o` is 1.
- R7: `done_o` is high for exactly one cycle, the cycle after the final chip-select rise. `busy_o` falls once the trailing chip-select-high time has elapsed.
- R8: A start pulse while `busy_o` is high has no effect. The pulse counts of the running sequence do not change, and no extra window or done pulse appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch request, honoured only while idle |
| busy_o | output | 1 | High from the accepted start until the trailing gap ends |
| done_o | output | 1 | One-cycle pulse after the final chip-select rise |
| cs_n_o | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | Flash serial clock |
| dq0_o | output | 1 | DQ0 level (constant 1) |
| dq0_oe_o | output | 1 | DQ0 output enable |
| dq3_o | output | 1 | DQ3 level (constant 1) |
| dq3_oe_o | output | 1 | DQ3 output enable |

## Verification
The embedded properties assume `start_i` is a clean synchronous pulse. They also assume the block is reset before use and that reset is never raised during a sequence. The bench therefore drives `start_i` for exactly one cycle on the falling clock edge. It raises mid-sequence start pulses only while `busy_o` is high, and starts the next sequence on the first cycle after `busy_o` drops, so the trailing gap is exercised against the new first burst. The parameters stay within SCK half-period ≥ 1 and a derived gap of at least one cycle. This keeps every timer load value non-negative.

// File: rtl/frs_pkg.sv
package frs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_GAP
  } frs_state_e;

  localparam int unsigned NUM_BURSTS = 4;
  localparam int unsigned IDX_W      = $clog2(NUM_BURSTS);
  localparam int unsigned PART2_IDX  = 3;
  localparam int unsigned MAX_PULSES = 25;
  localparam int unsigned PULSE_W    = $clog2(MAX_PULSES + 1);

  // Pulse count for each burst; order is behaviour (XIP exit first, then protocol reset)
  function automatic int unsigned burst_pulses(input int unsigned idx);
    case (idx)
      0:       return 7;
      1:       return 13;
      2:       return 25;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/frs_timer.sv
module frs_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/frs_pulse_ctr.sv
module frs_pulse_ctr #(
  parameter int unsigned PULSE_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               inc,
  input  logic [PULSE_W-1:0] limit,
  output logic               last
);

  logic [PULSE_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count_q <= '0;
    end else if (inc) begin
      count_q <= count_q + PULSE_W'(1);
    end
  end

  assign last = (count_q == limit - PULSE_W'(1));

  // R2: the running pulse index never passes the current burst length
  assert_pulse_bound_R2: assert property (@(posedge clk) disable iff (rst)
    count_q < limit);

endmodule

// File: rtl/frs_ctrl.sv
module frs_ctrl
  import frs_pkg::*;
#(
  parameter int unsigned HALF_CYC = 2,
  parameter int unsigned CSH_CYC  = 5,
  parameter int unsigned CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             tmr_expired_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             pc_clr_o,
  output logic             pc_inc_o,
  input  logic             pc_last_i,
  output logic [IDX_W-1:0] burst_idx_o,
  output logic             cs_n_o,
  output logic             sck_o,
  output logic             dq0_o,
  output logic             dq0_oe_o,
  output logic             dq3_o,
  output logic             dq3_oe_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] HALF_LD = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] CSH_LD  = CNT_W'(CSH_CYC - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BURSTS - 1);
  localparam logic [IDX_W-1:0] P2_IDX   = IDX_W'(PART2_IDX);

  frs_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             cs_n_q, sck_q, busy_q, dq3_oe_q, done_pend_q, done_q;
  logic             last_burst;

  assign last_burst = (idx_q == LAST_IDX);

  // Timer and pulse counter controls follow the state transitions
  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = HALF_LD;
    pc_clr_o   = 1'b0;
    pc_inc_o   = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        tmr_load_o = 1'b1;
        pc_clr_o   = 1'b1;
      end
      ST_LEAD, ST_HIGH: if (tmr_expired_i) tmr_load_o = 1'b1;
      ST_LOW: if (tmr_expired_i) begin
        tmr_load_o = 1'b1;
        if (pc_last_i) begin
          tmr_val_o = CSH_LD;
          pc_clr_o  = 1'b1;
        end else begin
          pc_inc_o  = 1'b1;
        end
      end
      ST_GAP: if (tmr_expired_i && !last_burst) tmr_load_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      cs_n_q      <= 1'b1;
      sck_q       <= 1'b0;
      busy_q      <= 1'b0;
      dq3_oe_q    <= 1'b0;
      done_pend_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q      <= done_pend_q;
      done_pend_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_LEAD;
          idx_q    <= '0;
          cs_n_q   <= 1'b0;
          busy_q   <= 1'b1;
          dq3_oe_q <= (P2_IDX == '0);
        end
        ST_LEAD: if (tmr_expired_i) begin
          sck_q   <= 1'b1;
          state_q <= ST_HIGH;
        end
        ST_HIGH: if (tmr_expired_i) begin
          sck_q   <= 1'b0;
          state_q <= ST_LOW;
        end
        ST_LOW: if (tmr_expired_i) begin
          if (pc_last_i) begin
            cs_n_q      <= 1'b1;
            state_q     <= ST_GAP;
            done_pend_q <= last_burst;
          end else begin
            sck_q   <= 1'b1;
            state_q <= ST_HIGH;
          end
        end
        ST_GAP: if (tmr_expired_i) begin
          if (last_burst) begin
            state_q  <= ST_IDLE;
            busy_q   <= 1'b0;
            dq3_oe_q <= 1'b0;
          end else begin
            idx_q    <= idx_q + IDX_W'(1);
            cs_n_q   <= 1'b0;
            state_q  <= ST_LEAD;
            dq3_oe_q <= (idx_q + IDX_W'(1) == P2_IDX);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign burst_idx_o = idx_q;
  assign cs_n_o      = cs_n_q;
  assign sck_o       = sck_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign dq0_o       = 1'b1;
  assign dq0_oe_o    = busy_q;
  assign dq3_o       = 1'b1;
  assign dq3_oe_o    = dq3_oe_q;

  // Chip-select-high run length, saturating at the required minimum
  logic [CNT_W-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= CNT_W'(CSH_CYC);
    end else if (cs_n_q) begin
      if (gap_q < CNT_W'(CSH_CYC)) gap_q <= gap_q + CNT_W'(1);
    end else begin
      gap_q <= '0;
    end
  end

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (cs_n_o && !sck_o && !dq3_oe_o && !dq0_oe_o));

  assert_sck_parked_R3: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sck_o);

  assert_cs_gap_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> (gap_q >= CNT_W'(CSH_CYC)));

  assert_dq0_drive_R5: assert property (@(posedge clk) disable iff (rst)
    !cs_n_o |-> (dq0_oe_o && dq0_o));

  assert_dq3_part2_R6: assert property (@(posedge clk) disable iff (rst)
    (dq3_oe_o && !cs_n_o) |-> (burst_idx_o == P2_IDX && dq3_o));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cs_n_o && $past(cs_n_o) && !$past(cs_n_o, 2) && !$past(done_o)));

endmodule

// File: rtl/frs_rescue_gen.sv
module frs_rescue_gen
  import frs_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned CS_HIGH_NS    = 50,
  parameter int unsigned SCK_HALF_CYC  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic cs_n_o,
  output logic sck_o,
  output logic dq0_o,
  output logic dq0_oe_o,
  output logic dq3_o,
  output logic dq3_oe_o
);

  localparam int unsigned CSH_RAW = (CS_HIGH_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int unsigned CSH_CYC = (CSH_RAW < 1) ? 1 : CSH_RAW;
  localparam int unsigned HALF    = (SCK_HALF_CYC < 1) ? 1 : SCK_HALF_CYC;
  localparam int unsigned CNT_MAX = (CSH_CYC > HALF) ? CSH_CYC : HALF;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;
  logic             pc_clr, pc_inc, pc_last;
  logic [IDX_W-1:0] burst_idx;
  logic [PULSE_W-1:0] pulse_limit;

  assign pulse_limit = PULSE_W'(burst_pulses(int'(burst_idx)));

  frs_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  frs_pulse_ctr #(.PULSE_W(PULSE_W)) pulse_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (pc_clr),
    .inc   (pc_inc),
    .limit (pulse_limit),
    .last  (pc_last)
  );

  frs_ctrl #(
    .HALF_CYC (HALF),
    .CSH_CYC  (CSH_CYC),
    .CNT_W    (CNT_W)
  ) ctrl_i (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .tmr_expired_i (tmr_expired),
    .tmr_load_o    (tmr_load),
    .tmr_val_o     (tmr_val),
    .pc_clr_o      (pc_clr),
    .pc_inc_o      (pc_inc),
    .pc_last_i     (pc_last),
    .burst_idx_o   (burst_idx),
    .cs_n_o        (cs_n_o),
    .sck_o         (sck_o),
    .dq0_o         (dq0_o),
    .dq0_oe_o      (dq0_oe_o),
    .dq3_o         (dq3_o),
    .dq3_oe_o      (dq3_oe_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

endmodule

// File: tb/frs_rescue_gen_tb_top.sv
`timescale 1ns/1ps
module frs_rescue_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CS_HIGH_NS = 50;
  localparam int HALF_CYC   = 2;
  localparam int CSH_EXP    = (CS_HIGH_NS + CLK_PERIOD - 1) / CLK_PERIOD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done, cs_n, sck, dq0, dq0_oe, dq3, dq3_oe;

  always #(CLK_PERIOD / 2) clk = ~clk;

  frs_rescue_gen #(
    .CLK_PERIOD_PS (CLK_PERIOD * 1000),
    .CS_HIGH_NS    (CS_HIGH_NS),
    .SCK_HALF_CYC  (HALF_CYC)
  ) dut_i (
    .clk (clk), .rst (rst), .start_i (start),
    .busy_o (busy), .done_o (done), .cs_n_o (cs_n), .sck_o (sck),
    .dq0_o (dq0), .dq0_oe_o (dq0_oe), .dq3_o (dq3), .dq3_oe_o (dq3_oe)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int exp_cnt[$];
  int exp_dq3[$];
  int done_cnt = 0;
  int r3_viol = 0, r3_phase_viol = 0, r5_viol = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops one expected window per chip-select-low burst
  bit prev_cs = 1'b1, prev2_cs = 1'b1, prev_sck = 1'b0, prev_done = 1'b0;
  int edges = 0, gap_cnt = 1000, phase_len = 0;
  bit dq3_all = 1'b0, dq3_any = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (cs_n && sck) r3_viol++;
      if (busy && !(dq0_oe && dq0)) r5_viol++;
      if (!busy && (dq0_oe || dq3_oe || !cs_n)) r5_viol++;
      if (!cs_n) begin
        if (prev_cs) begin
          check(gap_cnt >= CSH_EXP, "R4 gap", gap_cnt, CSH_EXP);
          edges = 0; dq3_all = 1'b1; dq3_any = 1'b0; phase_len = 0;
        end
        if (!prev_sck && sck) edges++;
        // R3: count each SCK level run inside the window
        if (!prev_cs && sck != prev_sck) begin
          if (phase_len != HALF_CYC) r3_phase_viol++;
          phase_len = 1;
        end else begin
          phase_len++;
        end
        dq3_all = dq3_all && dq3_oe && dq3;
        dq3_any = dq3_any || dq3_oe;
        gap_cnt = 0;
      end else begin
        gap_cnt++;
        if (!prev_cs) begin
          if (phase_len != HALF_CYC) r3_phase_viol++;
          if (exp_cnt.size() == 0) begin
            check(1'b0, "R8 unexpected window", edges, 0);
          end else begin
            int ec, ed;
            ec = exp_cnt.pop_front();
            ed = exp_dq3.pop_front();
            check(edges == ec, "R2 pulse count", edges, ec);
            if (ed != 0) check(dq3_all, "R6 dq3 driven high", dq3_all, 1);
            else         check(!dq3_any, "R6 dq3 released", dq3_any, 0);
          end
        end
      end
      if (done) begin
        done_cnt++;
        check(prev_cs && !prev2_cs && !prev_done, "R7 done timing",
              {prev2_cs, prev_cs, prev_done}, 3'b010);
      end
      prev2_cs  = prev_cs;
      prev_cs   = cs_n;
      prev_sck  = sck;
      prev_done = done;
    end
  end

  task automatic run_seq(input int noise_pulses);
    int d0;
    d0 = done_cnt;
    exp_cnt.push_back(7);  exp_dq3.push_back(0);
    exp_cnt.push_back(13); exp_dq3.push_back(0);
    exp_cnt.push_back(25); exp_dq3.push_back(0);
    exp_cnt.push_back(8);  exp_dq3.push_back(1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R7 busy after start", busy, 1);
    for (int i = 0; i < noise_pulses; i++) begin
      repeat (37) @(negedge clk);
      if (busy) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    while (busy) @(negedge clk);
    check(done_cnt == d0 + 1, "R7 single done", done_cnt - d0, 1);
    check(exp_cnt.size() == 0, "R2 all windows seen", exp_cnt.size(), 0);
    check(cs_n && !sck && !dq0_oe && !dq3_oe && !done, "R1 idle after run",
          {cs_n, sck, dq0_oe, dq3_oe, done}, 5'b10000);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n && !sck && !busy && !done && !dq0_oe && !dq3_oe, "R1 reset state",
          {cs_n, sck, busy, done, dq0_oe, dq3_oe}, 6'b100000);
    repeat (3) @(negedge clk);
    run_seq(0);            // plain sequence
    run_seq(0);            // back-to-back start: trailing gap guards R4
    repeat (5) @(negedge clk);
    run_seq(5);            // R8: start pulses while busy are ignored
    repeat (10) @(negedge clk);
    check(done_cnt == 3, "R8 total done count", done_cnt, 3);
    check(r3_viol == 0, "R3 sck parked while cs high", r3_viol, 0);
    check(r3_phase_viol == 0, "R3 half-period length", r3_phase_viol, 0);
    check(r5_viol == 0, "R5 dq0 drive while busy", r5_viol, 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule